// File: doc/BRIEF.md
# Fault Input Level Detector

This block watches four active-low fault pins and decides for each pin when a fault has happened. A pin in edge mode reports a fault on a falling edge. A pin in level mode reports a fault only after it has been seen low on sixteen consecutive samples. Those samples are taken on a strobe derived from the clock, at one eighth, one sixteenth or one hundred twenty-eighth of the clock rate. Every pin passes through a two-flop synchroniser before it is evaluated.

A detection sets a sticky per-pin flag. The flags of pins 0 to 2 are combined into the fault output for the complementary PWM group. The flag of pin 3 drives the fault output for the single-timer group. Downstream logic uses these two outputs to put driver pins in high impedance. Each pin can also feed its group's interrupt request through an enable.

Software sets the mode and the rate of each pin with a single write. That write locks the pin's setting until the next reset. Software clears a flag by first reading it as one and then writing zero to it.

Top module: `fault_lvl_detect`

## Requirements
- R1: After reset, all flags, both fault outputs and both interrupt outputs are 0. Every pin starts in edge mode with the rate field at 00 and is unlocked.
- R2: Each pin goes through two synchroniser flops. A low level driven before clock edge k sets the edge-mode flag at edge k+2, and the flag is still 0 after edge k+1.
- R3: In edge mode (cfg_level=0), a falling edge on the pin sets its flag. A rising edge has no effect.
- R4: In level mode (cfg_level=1), the flag is set on the sixteenth consecutive low sample. With a sample period of D clocks and the pin held low from edge k, the flag is set no earlier than edge k+2+15D and no later than edge k+1+16D.
- R5: In level mode, any high sample resets the consecutive-low count to zero.
- R6: The rate field cfg_div selects the sample period: 00 gives 8 clocks, 01 gives 16 clocks, and 10 or 11 give 128 clocks.
- R7: The first cfg_we write to a pin after reset sets its mode and rate and locks them. Later writes to that pin are ignored.
- R8: A flag clears only when flag_wr is high with flag_wdata bit 0 and that flag was read as 1 by a flag_rd strobe since it was last cleared. A write of zero without such a read leaves the flag at 1, and so does a write of one.
- R9: A detection in the same cycle as a valid clear leaves the flag at 1, and the pin must be read again before it can be cleared.
- R10: fault_pwm is the OR of flags 0 to 2. fault_tmr equals flag 3.
- R11: irq_pwm is the OR of flags 0 to 2, each masked by its irq_en bit. irq_tmr is flag 3 AND irq_en[3].
- R12: In level mode, one unbroken low run gives at most one detection. A flag cleared while the pin is still low stays clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_n | input | 4 | Active-low fault pins, asynchronous |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_pin | input | 2 | Pin addressed by the configuration write |
| cfg_level | input | 1 | 0 = edge mode, 1 = level mode |
| cfg_div | input | 2 | Sample-period select (see R6) |
| flag_rd | input | 1 | Flag read strobe; arms clearing of flags that read as 1 |
| flag_wr | input | 1 | Flag write strobe |
| flag_wdata | input | 4 | Flag write data; a 0 bit clears an armed flag |
| irq_en | input | 4 | Per-pin interrupt enable |
| flags | output | 4 | Sticky fault flags |
| fault_pwm | output | 1 | Fault for the PWM group (pins 0 to 2) |
| fault_tmr | output | 1 | Fault for the timer group (pin 3) |
| irq_pwm | output | 1 | Interrupt request for the PWM group |
| irq_tmr | output | 1 | Interrupt request for the timer group |

## Verification
A new detection on a pin and a software clear of that same pin's flag can land on the same clock edge. The bench provokes this by arming pin 3 with a read, driving its falling edge, and placing the zero write exactly two edges later, so it meets the synchronised detection. The flag must then read 1. A following zero write without a new read must leave it at 1, and after a fresh read a zero write must clear it.

// File: rtl/fld_pkg.sv
package fld_pkg;
  typedef enum logic { MODE_EDGE = 1'b0, MODE_LEVEL = 1'b1 } det_mode_e;
  typedef enum logic [1:0] {
    DIV_FAST = 2'b00, DIV_MID = 2'b01, DIV_SLOW = 2'b10, DIV_SLOW_ALT = 2'b11
  } div_sel_e;
  localparam int unsigned NUM_RATES = 3;
  localparam int unsigned RATE_DIV [NUM_RATES] = '{8, 16, 128};
  localparam int unsigned FILT_LEN = 16;
endpackage

// File: rtl/fld_sync.sv
module fld_sync #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  logic [WIDTH-1:0] meta_q, sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '1;
      sync_q <= '1;
    end else begin
      meta_q <= d_async;
      sync_q <= meta_q;
    end
  end

  assign q_sync = sync_q;
endmodule

// File: rtl/fld_prescaler.sv
module fld_prescaler import fld_pkg::*; (
  input  logic                 clk,
  input  logic                 rst_n,
  output logic [NUM_RATES-1:0] tick
);
  localparam int unsigned CW = $clog2(RATE_DIV[NUM_RATES-1]);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb cnt_d = cnt_q + CW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  for (genvar r = 0; r < NUM_RATES; r++) begin : g_tick
    localparam logic [CW-1:0] MASK = CW'(RATE_DIV[r] - 1);
    assign tick[r] = ((cnt_q & MASK) == MASK);
  end

  // R6
  nested_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick[NUM_RATES-1] |-> tick[0]);
endmodule

// File: rtl/fld_pin_detect.sv
module fld_pin_detect import fld_pkg::*; (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pin_s,
  input  logic [NUM_RATES-1:0] tick,
  input  logic                 wr_en,
  input  logic                 wr_level,
  input  logic [1:0]           wr_div,
  output logic                 det
);
  localparam int unsigned CW = $clog2(FILT_LEN + 1);
  localparam logic [CW-1:0] FULL = CW'(FILT_LEN);
  localparam logic [CW-1:0] LAST = CW'(FILT_LEN - 1);

  det_mode_e     mode_q, mode_d;
  div_sel_e      div_q, div_d;
  logic          lock_q, lock_d;
  logic          prev_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          smp_tick, lvl_hit;

  always_comb begin
    mode_d = mode_q;
    div_d  = div_q;
    lock_d = lock_q;
    if (wr_en && !lock_q) begin
      mode_d = det_mode_e'(wr_level);
      div_d  = div_sel_e'(wr_div);
      lock_d = 1'b1;
    end
  end

  always_comb begin
    unique case (div_q)
      DIV_FAST: smp_tick = tick[0];
      DIV_MID:  smp_tick = tick[1];
      default:  smp_tick = tick[2];
    endcase
  end

  always_comb begin
    cnt_d   = cnt_q;
    lvl_hit = 1'b0;
    if (mode_q == MODE_EDGE) begin
      cnt_d = '0;
    end else if (smp_tick) begin
      if (pin_s) begin
        cnt_d = '0;
      end else if (cnt_q < FULL) begin
        cnt_d   = cnt_q + CW'(1);
        lvl_hit = (cnt_q == LAST);
      end
    end
  end

  assign det = (mode_q == MODE_EDGE) ? (prev_q & ~pin_s) : lvl_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_EDGE;
      div_q  <= DIV_FAST;
      lock_q <= 1'b0;
      prev_q <= 1'b1;
      cnt_q  <= '0;
    end else begin
      mode_q <= mode_d;
      div_q  <= div_d;
      lock_q <= lock_d;
      prev_q <= pin_s;
      cnt_q  <= cnt_d;
    end
  end

  // R4
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL);
  // R7
  cfg_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> ($stable(mode_q) && $stable(div_q)));
  // R4
  lvl_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (det && mode_q == MODE_LEVEL) |-> (smp_tick && !pin_s));
  // R5
  high_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_LEVEL && smp_tick && pin_s) |=> (cnt_q == '0));
endmodule

// File: rtl/fault_lvl_detect.sv
module fault_lvl_detect import fld_pkg::*; #(
  parameter int unsigned NUM_PINS = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_PINS-1:0]         pin_n,
  input  logic                        cfg_we,
  input  logic [$clog2(NUM_PINS)-1:0] cfg_pin,
  input  logic                        cfg_level,
  input  logic [1:0]                  cfg_div,
  input  logic                        flag_rd,
  input  logic                        flag_wr,
  input  logic [NUM_PINS-1:0]         flag_wdata,
  input  logic [NUM_PINS-1:0]         irq_en,
  output logic [NUM_PINS-1:0]         flags,
  output logic                        fault_pwm,
  output logic                        fault_tmr,
  output logic                        irq_pwm,
  output logic                        irq_tmr
);
  localparam int unsigned PW   = $clog2(NUM_PINS);
  localparam int unsigned NPWM = NUM_PINS - 1;

  logic [1:0]           rst_pipe_q;
  logic                 rst_n_s;
  logic [NUM_PINS-1:0]  pin_s, det;
  logic [NUM_RATES-1:0] tick;
  logic [NUM_PINS-1:0]  flag_q, flag_d, armed_q, armed_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_s = rst_pipe_q[1];

  fld_sync #(.WIDTH(NUM_PINS)) u_sync (
    .clk(clk), .rst_n(rst_n_s), .d_async(pin_n), .q_sync(pin_s)
  );

  fld_prescaler u_presc (.clk(clk), .rst_n(rst_n_s), .tick(tick));

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    fld_pin_detect u_det (
      .clk(clk), .rst_n(rst_n_s), .pin_s(pin_s[i]), .tick(tick),
      .wr_en(cfg_we && (cfg_pin == PW'(i))),
      .wr_level(cfg_level), .wr_div(cfg_div), .det(det[i])
    );

    always_comb begin
      flag_d[i]  = flag_q[i];
      armed_d[i] = armed_q[i];
      if (flag_rd && flag_q[i]) armed_d[i] = 1'b1;
      if (flag_wr && !flag_wdata[i] && armed_q[i]) begin
        flag_d[i]  = 1'b0;
        armed_d[i] = 1'b0;
      end
      if (det[i]) flag_d[i] = 1'b1;
    end

    // R3
    det_sets_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
      det[i] |=> flag_q[i]);
    // R8
    clr_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
      $fell(flag_q[i]) |-> $past(armed_q[i] && flag_wr && !flag_wdata[i]));
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      flag_q  <= '0;
      armed_q <= '0;
    end else begin
      flag_q  <= flag_d;
      armed_q <= armed_d;
    end
  end

  assign flags     = flag_q;
  assign fault_pwm = |flag_q[NPWM-1:0];
  assign fault_tmr = flag_q[NUM_PINS-1];
  assign irq_pwm   = |(flag_q[NPWM-1:0] & irq_en[NPWM-1:0]);
  assign irq_tmr   = flag_q[NUM_PINS-1] & irq_en[NUM_PINS-1];

  // R10
  tmr_follow_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    fault_tmr |-> flags[NUM_PINS-1]);
  // R11
  irq_implies_fault_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    irq_pwm |-> fault_pwm);
endmodule

// File: tb/fault_lvl_detect_bench.sv
module fault_lvl_detect_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] pin_n;
  logic       cfg_we;
  logic [1:0] cfg_pin;
  logic       cfg_level;
  logic [1:0] cfg_div;
  logic       flag_rd, flag_wr;
  logic [3:0] flag_wdata, irq_en;
  logic [3:0] flags;
  logic       fault_pwm, fault_tmr, irq_pwm, irq_tmr;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  fault_lvl_detect u_fault_lvl_detect (
    .clk(clk), .rst_n(rst_n), .pin_n(pin_n), .cfg_we(cfg_we), .cfg_pin(cfg_pin),
    .cfg_level(cfg_level), .cfg_div(cfg_div), .flag_rd(flag_rd), .flag_wr(flag_wr),
    .flag_wdata(flag_wdata), .irq_en(irq_en), .flags(flags), .fault_pwm(fault_pwm),
    .fault_tmr(fault_tmr), .irq_pwm(irq_pwm), .irq_tmr(irq_tmr)
  );

  function automatic logic exp_irq_pwm(logic [3:0] f, logic [3:0] en);
    return |(f[2:0] & en[2:0]);
  endfunction

  function automatic logic exp_irq_tmr(logic [3:0] f, logic [3:0] en);
    return f[3] & en[3];
  endfunction

  task automatic chk(int act, int exp, string req, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic edges(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic cfg_write(int p, logic lvl, logic [1:0] dv);
    cfg_we = 1'b1; cfg_pin = 2'(p); cfg_level = lvl; cfg_div = dv;
    edges(1);
    cfg_we = 1'b0;
  endtask

  task automatic do_read();
    flag_rd = 1'b1; edges(1); flag_rd = 1'b0;
  endtask

  task automatic do_write(logic [3:0] d);
    flag_wr = 1'b1; flag_wdata = d; edges(1); flag_wr = 1'b0; flag_wdata = 4'hF;
  endtask

  task automatic level_window(int p, int d, string req);
    pin_n[p] = 1'b0;
    edges(2 + 15 * d);
    chk(flags[p], 0, req, "flag before 16th sample");
    edges(d);
    chk(flags[p], 1, req, "flag after 16th sample");
    pin_n[p] = 1'b1;
    edges(4);
    do_read();
    do_write(4'h0);
    chk(flags[p], 0, req, "flag cleared after level test");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [3:0] en;
    logic       exp3;
    void'($urandom(32'd1234));
    rst_n = 1'b0; pin_n = 4'hF; cfg_we = 1'b0; cfg_pin = '0; cfg_level = 1'b0;
    cfg_div = '0; flag_rd = 1'b0; flag_wr = 1'b0; flag_wdata = 4'hF; irq_en = 4'h0;
    edges(3);
    rst_n = 1'b1;
    edges(4);

    // R1 reset state
    chk(flags, 0, "R1", "flags after reset");
    chk({fault_pwm, fault_tmr, irq_pwm, irq_tmr}, 0, "R1", "outputs after reset");

    // R1 default edge mode, R2 latency, R3 falling edge
    pin_n[1] = 1'b0;
    edges(2);
    chk(flags[1], 0, "R2", "flag after two edges");
    edges(1);
    chk(flags[1], 1, "R2", "flag on third edge (default edge mode, R1 R3)");
    // R10 R11 group outputs
    chk(fault_pwm, 1, "R10", "fault_pwm with flag1");
    chk(fault_tmr, 0, "R10", "fault_tmr with flag1");
    chk(irq_pwm, 0, "R11", "irq_pwm masked");
    irq_en = 4'b0010;
    edges(1);
    chk(irq_pwm, 1, "R11", "irq_pwm enabled");
    irq_en = 4'h0;
    do_read();
    do_write(4'h0);
    chk(flags[1], 0, "R8", "clear after read");
    // R3 rising edge ignored
    pin_n[1] = 1'b1;
    edges(6);
    chk(flags[1], 0, "R3", "rising edge no effect");

    // configuration: R6 R7
    cfg_write(0, 1'b1, 2'b00);
    cfg_write(1, 1'b1, 2'b01);
    cfg_write(2, 1'b1, 2'b11);
    cfg_write(3, 1'b0, 2'b00);
    cfg_write(0, 1'b0, 2'b00);
    cfg_write(3, 1'b1, 2'b10);

    // R7 pin0 still level: short low pulse ignored
    pin_n[0] = 1'b0; edges(4); pin_n[0] = 1'b1; edges(12);
    chk(flags[0], 0, "R7", "pin0 rewrite to edge ignored");
    // R7 pin3 still edge
    pin_n[3] = 1'b0; edges(3);
    chk(flags[3], 1, "R7", "pin3 rewrite to level ignored");
    pin_n[3] = 1'b1; edges(3);
    do_read(); do_write(4'h0);
    chk(flags[3], 0, "R8", "pin3 cleared");

    // R4 R6 windows for each rate
    level_window(0, 8, "R4");
    level_window(1, 16, "R6");
    level_window(2, 128, "R6");

    // R5 high sample resets count
    pin_n[0] = 1'b0; edges(80);
    pin_n[0] = 1'b1; edges(24);
    pin_n[0] = 1'b0;
    edges(2 + 15 * 8);
    chk(flags[0], 0, "R5", "count restarted after high sample");
    edges(8);
    chk(flags[0], 1, "R5", "detect after full new run");
    // R12 clear while still low stays clear
    do_read(); do_write(4'h0);
    edges(200);
    chk(flags[0], 0, "R12", "no second detect in same low run");
    pin_n[0] = 1'b1; edges(24);

    // R9 detection and clear in the same cycle
    pin_n[3] = 1'b0; edges(3); pin_n[3] = 1'b1; edges(3);
    do_read();
    pin_n[3] = 1'b0;
    edges(2);
    flag_wr = 1'b1; flag_wdata = 4'h0;
    edges(1);
    flag_wr = 1'b0; flag_wdata = 4'hF;
    chk(flags[3], 1, "R9", "set wins over clear");
    do_write(4'h0);
    chk(flags[3], 1, "R9", "needs new read after collision");
    do_read();
    do_write(4'hF);
    chk(flags[3], 1, "R8", "write one does not clear");
    do_write(4'h0);
    chk(flags[3], 0, "R8", "clear after read then zero");
    pin_n[3] = 1'b1; edges(3);

    // random mix: edge pulses on pin3, short level pulses on pin0, random enables
    exp3 = 1'b0;
    for (int it = 0; it < 40; it++) begin
      en = 4'($urandom);
      irq_en = en;
      if ($urandom % 2 == 1) begin
        pin_n[3] = 1'b0; edges(1 + int'($urandom % 6)); pin_n[3] = 1'b1;
        exp3 = 1'b1;
      end
      if ($urandom % 2 == 1) begin
        pin_n[0] = 1'b0; edges(1 + int'($urandom % 100)); pin_n[0] = 1'b1;
      end
      edges(20);
      chk(flags[3], exp3, "R3", "random pin3 flag");
      chk(flags[0], 0, "R4", "random short low on pin0");
      chk(irq_tmr, exp_irq_tmr(flags, en), "R11", "random irq_tmr");
      chk(irq_pwm, exp_irq_pwm(flags, en), "R11", "random irq_pwm");
      chk(fault_tmr, exp3, "R10", "random fault_tmr");
      if ($urandom % 3 == 0) begin
        do_read(); do_write(4'h0); exp3 = 1'b0;
      end else if ($urandom % 2 == 0) begin
        do_write(4'h0);
      end
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule